// File: doc/BRIEF.md
# Per-CPU Private Interrupt Arbiter

This block keeps the banked interrupt state that each CPU of a small cluster owns privately: sixteen software-generated interrupts (IDs 0 to 15) and sixteen private peripheral interrupts (IDs 16 to 31). Each CPU has its own pending vector, its own active vector and its own priority byte for every one of these 32 IDs. The priority bytes are held outside the block, in a priority store, and are read through a flat input bus.

A source raises an interrupt by presenting an ID and a target CPU for one cycle. For every CPU the block picks the most urgent pending ID and reports it with a valid flag. It drives an interrupt request line when that ID is more urgent than the CPU's running priority. An acknowledge strobe moves the winner from pending to active and returns its ID. An end-of-interrupt strobe carrying an ID retires it, and the running priority follows the active set. IDs from 32 upward, register decode and security state belong to other blocks.

Top module: `priv_irq_arbiter`

## Requirements
- R1: During and after a synchronous active-high reset, pending and active sets are empty, every CPU reports valid 0 with ID 1023, request 0, running priority 0xFF, acknowledge result 1023 and error 0.
- R2: A one-cycle assertion of ID N (5 bits, 0 to 31) for CPU c sets bit N of CPU c's pending set only, and no other CPU's state changes.
- R3: The reported highest pending ID is the pending ID whose priority byte has the numerically smallest value (smaller means more urgent). It is registered, so it reflects the pending set and priorities of the previous cycle.
- R4: Among pending IDs of equal priority the lowest ID wins, so software-generated IDs are preferred over private peripheral IDs at the same priority.
- R5: An acknowledge on CPU c while a valid ID exists returns that ID on the CPU's acknowledge result in the next cycle, sets its active bit and clears its pending bit. The result holds until the next acknowledge.
- R6: When an assertion and an acknowledge hit the same ID of the same CPU in one cycle, the acknowledge is applied first: the ID becomes active and stays pending.
- R7: An end-of-interrupt with ID below 32 clears that CPU's active bit if it is set. If the bit is clear, no state changes and the CPU's error output is 1 for exactly one cycle. An ID of 32 or more is ignored.
- R8: The running priority of an enabled CPU is the smallest priority byte over its active IDs, or 0xFF when none is active, registered one cycle after the active set.
- R9: While a CPU's enable input is 0 its running priority holds its value. Arbitration and acknowledges continue.
- R10: The request line of a CPU is 1 only when a valid ID exists and its priority byte is strictly smaller than the CPU's running priority, with the same registration as R3.
- R11: An acknowledge with no valid pending ID returns 1023 and changes neither the pending nor the active set.
- R12: The priority byte of CPU c for ID i is read from bits [(c*32+i)*8 +: 8] of the priority bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_en_i | input | NUM_CPU | Per-CPU interface enable (running priority update) |
| prio_i | input | NUM_CPU*32*PRIO_W | Banked priority bytes from the external store |
| ast_valid_i | input | 1 | Interrupt assertion strobe |
| ast_cpu_i | input | CPU_W | Target CPU of the assertion |
| ast_id_i | input | 5 | Asserted interrupt ID |
| ack_i | input | NUM_CPU | Per-CPU acknowledge strobe |
| eoi_i | input | NUM_CPU | Per-CPU end-of-interrupt strobe |
| eoi_id_i | input | NUM_CPU*ID_W | Per-CPU ID being retired |
| hp_valid_o | output | NUM_CPU | A pending ID exists |
| hp_id_o | output | NUM_CPU*ID_W | Highest pending ID, 1023 when none |
| irq_o | output | NUM_CPU | Interrupt request line |
| rpr_o | output | NUM_CPU*PRIO_W | Running priority |
| ack_id_o | output | NUM_CPU*ID_W | ID returned by the last acknowledge |
| eoi_err_o | output | NUM_CPU | End-of-interrupt for an inactive ID |

## Verification
The assertions watch, on every cycle, that an asserted ID is pending in the next cycle even under a same-cycle acknowledge, that an active bit only falls after a matching end-of-interrupt, that a spurious acknowledge sets no active bit, that an idle active set gives 0xFF and a disabled CPU holds its running priority, and that a request never appears without a valid ID. The arbitration order itself, covering strict minimum, tie break by lowest ID, per-CPU banking of priorities and the one-cycle error pulse, shows only in the bench's directed scenarios and in its cycle-by-cycle comparison against a behavioural model under random traffic.

// File: rtl/pia_pkg.sv
package pia_pkg;
  // ID returned when nothing can be handed out
  localparam int unsigned SPUR_ID = 1023;

  // A candidate replaces the current best only when nothing was found yet
  // or its priority value is strictly smaller; equal values keep the lower ID.
  function automatic logic beats(input logic have, input logic [15:0] cand,
                                 input logic [15:0] best);
    return !have || (cand < best);
  endfunction
endpackage

// File: rtl/pia_select.sv
module pia_select #(
  parameter int unsigned N      = 32,
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned IDX_W  = 5
) (
  input  logic [N-1:0]        req_i,
  input  logic [N*PRIO_W-1:0] prio_i,
  output logic                found_o,
  output logic [IDX_W-1:0]    idx_o,
  output logic [PRIO_W-1:0]   prio_o
);
  logic [PRIO_W-1:0] pr [N];

  for (genvar i = 0; i < N; i++) begin : g_unpack
    assign pr[i] = prio_i[i*PRIO_W +: PRIO_W];
  end

  // Ascending scan: the lowest ID wins among equal values.
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    prio_o  = '1;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && pia_pkg::beats(found_o, 16'(pr[i]), 16'(prio_o))) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
        prio_o  = pr[i];
      end
    end
  end
endmodule

// File: rtl/pia_runprio.sv
module pia_runprio #(
  parameter int unsigned N      = 32,
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned IDX_W  = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en_i,
  input  logic [N-1:0]        act_i,
  input  logic [N*PRIO_W-1:0] prio_i,
  output logic [PRIO_W-1:0]   rpr_o
);
  logic              any_act;
  logic [IDX_W-1:0]  top_idx;
  logic [PRIO_W-1:0] top_pr;

  pia_select #(.N(N), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_min (
    .req_i   (act_i),
    .prio_i  (prio_i),
    .found_o (any_act),
    .idx_o   (top_idx),
    .prio_o  (top_pr)
  );

  always_ff @(posedge clk) begin
    if (rst)       rpr_o <= '1;
    else if (en_i) rpr_o <= any_act ? top_pr : '1;
  end

  // R8: the minimum is taken from an ID that is really active
  a_r8_min_from_active: assert property (@(posedge clk) disable iff (rst)
    any_act |-> act_i[top_idx]);
  // R8: nothing active on an enabled CPU gives the idle value
  a_r8_idle_ff: assert property (@(posedge clk) disable iff (rst)
    $past(en_i && (act_i == '0)) |-> (rpr_o == '1));
  // R9: a disabled CPU keeps its running priority
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(rpr_o));
endmodule

// File: rtl/pia_cpu.sv
module pia_cpu #(
  parameter int unsigned PRIV   = 32,
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned ID_W   = 10,
  parameter int unsigned IDX_W  = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en_i,
  input  logic [PRIV-1:0]        set_i,
  input  logic [PRIV*PRIO_W-1:0] prio_i,
  input  logic                   ack_i,
  input  logic                   eoi_i,
  input  logic [ID_W-1:0]        eoi_id_i,
  output logic                   hp_valid_o,
  output logic [ID_W-1:0]        hp_id_o,
  output logic                   irq_o,
  output logic [PRIO_W-1:0]      rpr_o,
  output logic [ID_W-1:0]        ack_id_o,
  output logic                   eoi_err_o
);
  localparam logic [ID_W-1:0] SPUR = ID_W'(pia_pkg::SPUR_ID);

  logic [PRIV-1:0]   pend_q, act_q, ack_clr, eoi_clr;
  logic              best_v;
  logic [IDX_W-1:0]  best_idx;
  logic [PRIO_W-1:0] best_pr;
  logic              eoi_priv;
  logic [IDX_W-1:0]  eoi_idx;

  pia_select #(.N(PRIV), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pend (
    .req_i   (pend_q),
    .prio_i  (prio_i),
    .found_o (best_v),
    .idx_o   (best_idx),
    .prio_o  (best_pr)
  );

  pia_runprio #(.N(PRIV), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_run (
    .clk    (clk),
    .rst    (rst),
    .en_i   (en_i),
    .act_i  (act_q),
    .prio_i (prio_i),
    .rpr_o  (rpr_o)
  );

  assign eoi_priv = eoi_i && (eoi_id_i < ID_W'(PRIV));
  assign eoi_idx  = eoi_id_i[IDX_W-1:0];

  always_comb begin
    ack_clr = '0;
    eoi_clr = '0;
    if (ack_i && best_v)                ack_clr[best_idx] = 1'b1;
    if (eoi_priv && act_q[eoi_idx])     eoi_clr[eoi_idx]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= '0;
      act_q      <= '0;
      hp_valid_o <= 1'b0;
      hp_id_o    <= SPUR;
      irq_o      <= 1'b0;
      ack_id_o   <= SPUR;
      eoi_err_o  <= 1'b0;
    end else begin
      // acknowledge clears first, a new assertion then sets again
      pend_q     <= (pend_q & ~ack_clr) | set_i;
      act_q      <= (act_q & ~eoi_clr) | ack_clr;
      hp_valid_o <= best_v;
      hp_id_o    <= best_v ? ID_W'(best_idx) : SPUR;
      irq_o      <= best_v && (best_pr < rpr_o);
      if (ack_i) ack_id_o <= best_v ? ID_W'(best_idx) : SPUR;
      eoi_err_o  <= eoi_priv && !act_q[eoi_idx];
    end
  end

  for (genvar k = 0; k < PRIV; k++) begin : g_chk
    // R2 / R6: an asserted ID is pending next cycle, even under an acknowledge
    a_r6_set_kept: assert property (@(posedge clk) disable iff (rst)
      set_i[k] |=> pend_q[k]);
    // R7: an active bit only falls after a matching end-of-interrupt
    a_r7_clear_needs_eoi: assert property (@(posedge clk) disable iff (rst)
      $fell(act_q[k]) |-> $past(eoi_i && (eoi_id_i == ID_W'(k))));
  end

  // R5: an accepted acknowledge leaves the winner active
  a_r5_ack_sets_active: assert property (@(posedge clk) disable iff (rst)
    (ack_i && best_v) |=> act_q[$past(best_idx)]);
  // R11: a spurious acknowledge sets no active bit and returns 1023
  a_r11_spurious_quiet: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !best_v) |=> (((act_q & ~$past(act_q)) == '0) && (ack_id_o == SPUR)));
  // R10: no request without a valid pending ID
  a_r10_irq_needs_valid: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> hp_valid_o);
endmodule

// File: rtl/priv_irq_arbiter.sv
module priv_irq_arbiter #(
  parameter int unsigned NUM_CPU = 2,
  parameter int unsigned NUM_SGI = 16,
  parameter int unsigned NUM_PPI = 16,
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned ID_W    = 10,
  localparam int unsigned PRIV   = NUM_SGI + NUM_PPI,
  localparam int unsigned IDX_W  = $clog2(PRIV),
  localparam int unsigned CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_CPU-1:0]             cpu_en_i,
  input  logic [NUM_CPU*PRIV*PRIO_W-1:0] prio_i,
  input  logic                           ast_valid_i,
  input  logic [CPU_W-1:0]               ast_cpu_i,
  input  logic [IDX_W-1:0]               ast_id_i,
  input  logic [NUM_CPU-1:0]             ack_i,
  input  logic [NUM_CPU-1:0]             eoi_i,
  input  logic [NUM_CPU*ID_W-1:0]        eoi_id_i,
  output logic [NUM_CPU-1:0]             hp_valid_o,
  output logic [NUM_CPU*ID_W-1:0]        hp_id_o,
  output logic [NUM_CPU-1:0]             irq_o,
  output logic [NUM_CPU*PRIO_W-1:0]      rpr_o,
  output logic [NUM_CPU*ID_W-1:0]        ack_id_o,
  output logic [NUM_CPU-1:0]             eoi_err_o
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [PRIV-1:0] set_c;

    // route the assertion to its target CPU only
    always_comb begin
      set_c = '0;
      if (ast_valid_i && (ast_cpu_i == CPU_W'(c))) set_c[ast_id_i] = 1'b1;
    end

    pia_cpu #(.PRIV(PRIV), .PRIO_W(PRIO_W), .ID_W(ID_W), .IDX_W(IDX_W)) u_cpu (
      .clk        (clk),
      .rst        (rst),
      .en_i       (cpu_en_i[c]),
      .set_i      (set_c),
      .prio_i     (prio_i[c*PRIV*PRIO_W +: PRIV*PRIO_W]),
      .ack_i      (ack_i[c]),
      .eoi_i      (eoi_i[c]),
      .eoi_id_i   (eoi_id_i[c*ID_W +: ID_W]),
      .hp_valid_o (hp_valid_o[c]),
      .hp_id_o    (hp_id_o[c*ID_W +: ID_W]),
      .irq_o      (irq_o[c]),
      .rpr_o      (rpr_o[c*PRIO_W +: PRIO_W]),
      .ack_id_o   (ack_id_o[c*ID_W +: ID_W]),
      .eoi_err_o  (eoi_err_o[c])
    );
  end
endmodule

// File: tb/sim_priv_irq_arbiter.sv
module sim_priv_irq_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 2;
  localparam int NP = 32;
  localparam int PW = 8;
  localparam int IW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NC-1:0]       cpu_en = '1;
  logic [NC*NP*PW-1:0] prio_bus = '0;
  logic                ast_valid = 1'b0;
  logic                ast_cpu = 1'b0;
  logic [4:0]          ast_id = '0;
  logic [NC-1:0]       ack = '0;
  logic [NC-1:0]       eoi = '0;
  logic [NC*IW-1:0]    eoi_id = '0;
  logic [NC-1:0]       hp_valid, irq, eoi_err;
  logic [NC*IW-1:0]    hp_id, ack_id;
  logic [NC*PW-1:0]    rpr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  priv_irq_arbiter #(.NUM_CPU(NC), .PRIO_W(PW), .ID_W(IW)) u0 (
    .clk(clk), .rst(rst), .cpu_en_i(cpu_en), .prio_i(prio_bus),
    .ast_valid_i(ast_valid), .ast_cpu_i(ast_cpu), .ast_id_i(ast_id),
    .ack_i(ack), .eoi_i(eoi), .eoi_id_i(eoi_id),
    .hp_valid_o(hp_valid), .hp_id_o(hp_id), .irq_o(irq), .rpr_o(rpr),
    .ack_id_o(ack_id), .eoi_err_o(eoi_err)
  );

  // ---------------- behavioural reference ----------------
  bit [31:0] m_pend [NC];
  bit [31:0] m_act  [NC];
  int m_rpr [NC], e_hpv [NC], e_hpid [NC], e_irq [NC], e_ack [NC], e_err [NC];

  function automatic int prio_of(int c, int i);
    return int'(prio_bus[(c*NP+i)*PW +: PW]);
  endfunction

  always @(posedge clk) begin
    for (int c = 0; c < NC; c++) begin
      int bi, bp, ap, eid;
      bit [31:0] clr, setb, ackb;
      if (rst) begin
        m_pend[c] = 0; m_act[c] = 0; m_rpr[c] = 255;
        e_hpv[c] = 0; e_hpid[c] = 1023; e_irq[c] = 0; e_ack[c] = 1023; e_err[c] = 0;
      end else begin
        bi = -1; bp = 256; ap = 255;
        for (int i = 0; i < NP; i++) begin
          if (m_pend[c][i] && prio_of(c, i) < bp) begin bi = i; bp = prio_of(c, i); end
          if (m_act[c][i] && prio_of(c, i) < ap) ap = prio_of(c, i);
        end
        e_hpv[c]  = (bi >= 0) ? 1 : 0;
        e_hpid[c] = (bi >= 0) ? bi : 1023;
        e_irq[c]  = (bi >= 0 && bp < m_rpr[c]) ? 1 : 0;
        ackb = 0;
        if (ack[c]) begin
          e_ack[c] = (bi >= 0) ? bi : 1023;
          if (bi >= 0) ackb[bi] = 1'b1;
        end
        clr = 0; e_err[c] = 0;
        eid = int'(eoi_id[c*IW +: IW]);
        if (eoi[c] && eid < NP) begin
          if (m_act[c][eid]) clr[eid] = 1'b1;
          else e_err[c] = 1;
        end
        setb = 0;
        if (ast_valid && int'(ast_cpu) == c) setb[ast_id] = 1'b1;
        if (cpu_en[c]) m_rpr[c] = ap;
        m_act[c]  = (m_act[c] & ~clr) | ackb;
        m_pend[c] = (m_pend[c] & ~ackb) | setb;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      for (int c = 0; c < NC; c++) begin
        chk("R3 hp_valid", int'(hp_valid[c]), e_hpv[c]);
        chk("R3 hp_id", int'(hp_id[c*IW +: IW]), e_hpid[c]);
        chk("R10 irq", int'(irq[c]), e_irq[c]);
        chk("R8 rpr", int'(rpr[c*PW +: PW]), m_rpr[c]);
        chk("R5 ack_id", int'(ack_id[c*IW +: IW]), e_ack[c]);
        chk("R7 eoi_err", int'(eoi_err[c]), e_err[c]);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic int hid(int c); return int'(hp_id[c*IW +: IW]); endfunction
  function automatic int aid(int c); return int'(ack_id[c*IW +: IW]); endfunction
  function automatic int rp(int c);  return int'(rpr[c*PW +: PW]); endfunction

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic set_prio(int c, int i, int v);
    prio_bus[(c*NP+i)*PW +: PW] = PW'(v);
  endtask
  task automatic pulse_ast(int c, int id);
    ast_valid = 1'b1; ast_cpu = c[0]; ast_id = 5'(id);
    @(negedge clk);
    ast_valid = 1'b0;
  endtask
  task automatic pulse_ack(int c);
    ack[c] = 1'b1;
    @(negedge clk);
    ack = '0;
  endtask
  task automatic pulse_eoi(int c, int id);
    eoi[c] = 1'b1; eoi_id[c*IW +: IW] = IW'(id);
    @(negedge clk);
    eoi = '0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < NP; i++) set_prio(c, i, (c == 0) ? 8'h80 : 8'h40);
    wait_n(5);
    rst = 1'b0;
    wait_n(1);
    // R1: reset state
    chk("R1 hp_valid0", int'(hp_valid[0]), 0);
    chk("R1 hp_id1", hid(1), 1023);
    chk("R1 rpr0", rp(0), 255);
    chk("R1 ack_id0", aid(0), 1023);
    chk("R1 irq", int'(irq), 0);

    // R2: target CPU only
    pulse_ast(0, 20); wait_n(1);
    chk("R2 hp_id0", hid(0), 20);
    chk("R2 hp_valid1", int'(hp_valid[1]), 0);
    chk("R10 irq0 raised", int'(irq[0]), 1);

    // R4: equal priority, lower ID wins
    pulse_ast(0, 5); wait_n(1);
    chk("R4 tie lowest id", hid(0), 5);

    // R3 / R12: more urgent value from the store wins
    set_prio(0, 20, 8'h10); wait_n(1);
    chk("R3 R12 lowest value", hid(0), 20);

    // R5: acknowledge
    pulse_ack(0);
    chk("R5 ack returns id", aid(0), 20);
    wait_n(1);
    chk("R5 pending cleared", hid(0), 5);
    chk("R8 rpr from active", rp(0), 16);
    wait_n(1);
    chk("R10 irq masked by rpr", int'(irq[0]), 0);

    // R7: end-of-interrupt and its error
    pulse_eoi(0, 20);
    chk("R7 good eoi no err", int'(eoi_err[0]), 0);
    wait_n(1);
    chk("R8 rpr idle", rp(0), 255);
    pulse_eoi(0, 20);
    chk("R7 inactive eoi err", int'(eoi_err[0]), 1);
    wait_n(1);
    chk("R7 err one cycle", int'(eoi_err[0]), 0);
    pulse_eoi(0, 40);
    chk("R7 id above range ignored", int'(eoi_err[0]), 0);

    // R11: spurious acknowledge
    pulse_ack(1);
    chk("R11 spurious id", aid(1), 1023);
    wait_n(1);
    chk("R11 no active", rp(1), 255);

    // R6: same-cycle assert and acknowledge
    pulse_ast(1, 17); wait_n(1);
    ack[1] = 1'b1; ast_valid = 1'b1; ast_cpu = 1'b1; ast_id = 5'd17;
    @(negedge clk);
    ack = '0; ast_valid = 1'b0;
    chk("R6 ack id", aid(1), 17);
    wait_n(1);
    chk("R6 still pending", hid(1), 17);
    chk("R6 active", rp(1), 64);

    // R9: disabled CPU holds running priority
    cpu_en[1] = 1'b0;
    pulse_eoi(1, 17); wait_n(2);
    chk("R9 held", rp(1), 64);
    cpu_en[1] = 1'b1; wait_n(1);
    chk("R9 resumed", rp(1), 255);

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      ast_valid = ($urandom % 3) == 0;
      ast_cpu   = 1'($urandom);
      ast_id    = 5'($urandom);
      ack       = NC'(($urandom % 5) == 0 ? $urandom : 0);
      eoi       = NC'(($urandom % 4) == 0 ? $urandom : 0);
      for (int c = 0; c < NC; c++) eoi_id[c*IW +: IW] = IW'($urandom % 36);
      if (($urandom % 6) == 0) set_prio(int'($urandom % NC), int'($urandom % NP), int'($urandom % 8) * 32);
      if (($urandom % 50) == 0) cpu_en = NC'($urandom);
      @(negedge clk);
    end
    ast_valid = 1'b0; ack = '0; eoi = '0; cpu_en = '1;
    wait_n(3);
    finish_run();
  end
endmodule